// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block sits between a local memory-mapped master with a narrow address window and an outbound request port that takes wide addresses. The local window is cut into equal pages. A field of the local address picks one entry from a small table that software programs. The chosen entry supplies the upper outbound address bits. Bit 0 of the entry chooses whether the outbound request carries a 32-bit or a 64-bit address. The offset within the page passes through unchanged.

Software loads the table through a word-addressed register port. Each entry is two 32-bit words. Read and write strobes and the wait signal go straight through the block. Translation is purely combinational, so the outbound address is valid in the same cycle as the local request. A build parameter turns translation off. In that mode a 64-bit local address passes through untouched.

Top module: `page_xlate`

## Requirements
- R1: With default parameters the local address is 20 bits wide, and local bits [19:16] select one of 16 table entries (entry 0 through entry 15).
- R2: Outbound address bits [15:0] always equal local address bits [15:0].
- R3: When the selected entry has bit 0 = 1, outbound bits [63:16] equal entry bits [63:16] and `out_is64` is high.
- R4: When the selected entry has bit 0 = 0, outbound bits [31:16] equal entry bits [31:16], outbound bits [63:32] are zero and `out_is64` is low.
- R5: Register word address bits [4:1] select the entry. Address bit 0 = 0 selects entry bits [31:0] and bit 0 = 1 selects entry bits [63:32]. Every bit reads back as written. Read data appears in the cycle after `csr_rd` and holds when no read is made.
- R6: Entry bits [15:1] have no effect on the outbound address or on `out_is64`.
- R7: A table write is used by requests in the cycle after the write. A request made in the same cycle as the write sees the old entry.
- R8: After reset every entry is zero. Outbound bits [63:16] are therefore zero, `out_is64` is low, and read-back returns zero.
- R9: `out_read`, `out_write` and `loc_wait` follow `loc_read`, `loc_write` and `out_wait` in the same cycle.
- R10: With the bypass parameter set, the local address is 64 bits wide and passes unchanged. `out_is64` is high exactly when local bits [63:32] are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_read | input | 1 | Local read strobe |
| loc_write | input | 1 | Local write strobe |
| loc_addr | input | LOC_AW (20) | Local byte address |
| loc_wait | output | 1 | Stall back to the local master |
| out_read | output | 1 | Outbound read strobe |
| out_write | output | 1 | Outbound write strobe |
| out_addr | output | 64 | Translated outbound address |
| out_is64 | output | 1 | High for a 64-bit address, low for 32-bit |
| out_wait | input | 1 | Stall from the outbound port |
| csr_wr | input | 1 | Table word write strobe |
| csr_rd | input | 1 | Table word read strobe |
| csr_addr | input | CSR_AW (5) | Table word address |
| csr_wdata | input | 32 | Table write data |
| csr_rdata | output | 32 | Table read data, one cycle after the read |

## Verification
The assertions assume that the register strobes are held low while reset is asserted. They also assume that a register read that directly follows a write to the same word is not itself paired with a second write. The bench drives every register access as a single isolated strobe. It holds all inputs at zero through reset. When it places a write and a request in the same cycle, it does so only in the one dedicated case that checks ordering. The bench also uses only power-of-two table sizes, because the word-address decoding relies on them.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int OUT_W   = 64;
  localparam int CSR_DW  = 32;
  localparam int WIDE_BIT = 0;
  typedef logic [OUT_W-1:0] pg_entry_t;
endpackage

// File: rtl/pgx_rst_sync.sv
module pgx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/pgx_page_table.sv
module pgx_page_table
  import pgx_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int SEL_W  = $clog2(NUM_PAGES),
  localparam int CSR_AW = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output pg_entry_t         rd_entry
);
  pg_entry_t tbl_q [NUM_PAGES];
  pg_entry_t tbl_d [NUM_PAGES];
  logic [CSR_DW-1:0] rdata_q, rdata_d;
  logic [SEL_W-1:0]  widx;
  logic              whi;

  assign widx = csr_addr[CSR_AW-1:1];
  assign whi  = csr_addr[0];

  always_comb begin
    tbl_d = tbl_q;
    if (whi) tbl_d[widx][OUT_W-1:CSR_DW] = csr_wdata;
    else     tbl_d[widx][CSR_DW-1:0]     = csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_q <= '{default: '0};
    else if (csr_wr) tbl_q <= tbl_d;
  end

  always_comb begin
    if (whi) rdata_d = tbl_q[widx][OUT_W-1:CSR_DW];
    else     rdata_d = tbl_q[widx][CSR_DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (csr_rd) rdata_q <= rdata_d;
  end

  assign csr_rdata = rdata_q;
  assign rd_entry  = tbl_q[rd_sel];

  // R5: data is held between reads
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> $stable(csr_rdata));

  // R5: a word written and then read returns the written value
  p_wr_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(csr_wr) && csr_rd && !csr_wr && csr_addr == $past(csr_addr))
    |=> csr_rdata == $past(csr_wdata, 2));
endmodule

// File: rtl/pgx_addr_compose.sv
module pgx_addr_compose
  import pgx_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_BITS = 16,
  parameter bit BYPASS    = 1'b0,
  localparam int SEL_W  = $clog2(NUM_PAGES),
  localparam int LOC_AW = BYPASS ? OUT_W : PAGE_BITS + SEL_W
) (
  input  logic [LOC_AW-1:0] loc_addr,
  output logic [SEL_W-1:0]  sel,
  input  pg_entry_t         entry,
  output logic [OUT_W-1:0]  out_addr,
  output logic              out_is64
);
  logic unused_bits;

  generate
    if (BYPASS) begin : g_bypass
      assign sel         = '0;
      assign out_addr    = loc_addr;
      assign out_is64    = |loc_addr[OUT_W-1:32];
      assign unused_bits = ^entry;
    end else begin : g_xlate
      assign sel = loc_addr[LOC_AW-1:PAGE_BITS];
      always_comb begin
        if (entry[WIDE_BIT])
          out_addr = {entry[OUT_W-1:PAGE_BITS], loc_addr[PAGE_BITS-1:0]};
        else
          out_addr = {32'b0, entry[31:PAGE_BITS], loc_addr[PAGE_BITS-1:0]};
      end
      assign out_is64    = entry[WIDE_BIT];
      assign unused_bits = ^entry[PAGE_BITS-1:1];
    end
  endgenerate
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pgx_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_BITS = 16,
  parameter bit BYPASS    = 1'b0,
  localparam int SEL_W  = $clog2(NUM_PAGES),
  localparam int LOC_AW = BYPASS ? OUT_W : PAGE_BITS + SEL_W,
  localparam int CSR_AW = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_read,
  input  logic              loc_write,
  input  logic [LOC_AW-1:0] loc_addr,
  output logic              loc_wait,
  output logic              out_read,
  output logic              out_write,
  output logic [OUT_W-1:0]  out_addr,
  output logic              out_is64,
  input  logic              out_wait,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata
);
  logic       rst_q;
  logic [SEL_W-1:0] sel_w;
  pg_entry_t  entry_w;

  pgx_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  pgx_page_table #(.NUM_PAGES(NUM_PAGES)) i_table (
    .clk(clk), .rst_n(rst_q),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_sel(sel_w), .rd_entry(entry_w)
  );

  pgx_addr_compose #(.NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .BYPASS(BYPASS)) i_compose (
    .loc_addr(loc_addr), .sel(sel_w), .entry(entry_w),
    .out_addr(out_addr), .out_is64(out_is64)
  );

  assign out_read  = loc_read;
  assign out_write = loc_write;
  assign loc_wait  = out_wait;

  // R9: handshakes pass through unchanged
  p_hs_pass_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_read == loc_read) && (out_write == loc_write) && (loc_wait == out_wait));

  generate
    if (!BYPASS) begin : g_chk
      // R2: page offset reaches the outbound side untouched
      p_offset_r2: assert property (@(posedge clk) disable iff (!rst_q)
        (loc_read || loc_write) |-> out_addr[PAGE_BITS-1:0] == loc_addr[PAGE_BITS-1:0]);
      // R4: narrow requests carry zero upper bits
      p_narrow_zero_r4: assert property (@(posedge clk) disable iff (!rst_q)
        !out_is64 |-> out_addr[OUT_W-1:32] == '0);
      // R7: the width flag written last cycle is the one in use now
      p_wr_visible_r7: assert property (@(posedge clk) disable iff (!rst_q)
        ($past(rst_q) && $past(csr_wr) && !$past(csr_addr[0]) &&
         $past(csr_addr[CSR_AW-1:1]) == sel_w && (loc_read || loc_write))
        |-> out_is64 == $past(csr_wdata[WIDE_BIT]));
    end
  endgenerate
endmodule

// File: tb/test_page_xlate.sv
module test_page_xlate;
  logic clk = 1'b0;
  logic rst_n;
  logic loc_read, loc_write, out_wait, csr_wr, csr_rd;
  logic [19:0] loc_addr;
  logic [4:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic        loc_wait, out_read, out_write, out_is64;
  logic [63:0] out_addr;
  logic [31:0] csr_rdata;

  logic [63:0] b_addr, b_out_addr;
  logic        b_is64, b_wait, b_rd, b_wr;
  logic [31:0] b_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  page_xlate i_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .loc_read(loc_read), .loc_write(loc_write), .loc_addr(loc_addr), .loc_wait(loc_wait),
    .out_read(out_read), .out_write(out_write), .out_addr(out_addr), .out_is64(out_is64),
    .out_wait(out_wait),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata)
  );

  page_xlate #(.BYPASS(1'b1)) i_page_xlate_byp (
    .clk(clk), .rst_n(rst_n),
    .loc_read(1'b1), .loc_write(1'b0), .loc_addr(b_addr), .loc_wait(b_wait),
    .out_read(b_rd), .out_write(b_wr), .out_addr(b_out_addr), .out_is64(b_is64),
    .out_wait(1'b0),
    .csr_wr(1'b0), .csr_rd(1'b0), .csr_addr(5'd0), .csr_wdata(32'd0),
    .csr_rdata(b_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = {idx, hi}; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [3:0] idx, input logic hi, output logic [31:0] d);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = {idx, hi};
    @(negedge clk);
    csr_rd = 1'b0;
    #1 d = csr_rdata;
  endtask

  task automatic probe(input logic [19:0] a);
    @(negedge clk);
    loc_read = 1'b1; loc_addr = a;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    probe(20'h3_1234);
    check("R8 addr after reset", out_addr, 64'h0000_0000_0000_1234);
    check("R8 width after reset", {63'b0, out_is64}, 64'd0);
    csr_read(4'd7, 1'b1, d);
    check("R8 readback high", {32'b0, d}, 64'd0);
    csr_read(4'd2, 1'b0, d);
    check("R8 readback low", {32'b0, d}, 64'd0);
  endtask

  task automatic t_handshake();
    @(negedge clk);
    loc_read = 1'b1; loc_write = 1'b0; out_wait = 1'b1;
    #1;
    check("R9 read pass", {63'b0, out_read}, 64'd1);
    check("R9 wait pass", {63'b0, loc_wait}, 64'd1);
    @(negedge clk);
    loc_read = 1'b0; loc_write = 1'b1; out_wait = 1'b0;
    #1;
    check("R9 write pass", {62'b0, out_write, out_read}, 64'd2);
    check("R9 wait low", {63'b0, loc_wait}, 64'd0);
    @(negedge clk);
    loc_write = 1'b0;
  endtask

  task automatic t_narrow();
    csr_write(4'd5, 1'b0, 32'hABCD_FFFE);
    csr_write(4'd5, 1'b1, 32'h1234_5678);
    probe(20'h5_BEEF);
    check("R4 R6 narrow addr", out_addr, 64'h0000_0000_ABCD_BEEF);
    check("R4 R6 narrow flag", {63'b0, out_is64}, 64'd0);
  endtask

  task automatic t_wide();
    csr_write(4'd9, 1'b0, 32'h89AB_0001);
    csr_write(4'd9, 1'b1, 32'hFEDC_BA98);
    probe(20'h9_0042);
    check("R3 wide addr", out_addr, 64'hFEDC_BA98_89AB_0042);
    check("R3 wide flag", {63'b0, out_is64}, 64'd1);
    csr_write(4'd15, 1'b0, 32'h0001_0003);
    csr_write(4'd15, 1'b1, 32'h8000_0000);
    probe(20'hF_FFFF);
    check("R1 R2 top entry", out_addr, 64'h8000_0000_0001_FFFF);
    probe(20'h0_0000);
    check("R1 bottom entry", out_addr, 64'd0);
    probe(20'h5_0001);
    check("R1 entry 5 unaffected", out_addr, 64'h0000_0000_ABCD_0001);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    csr_read(4'd5, 1'b0, d);
    check("R5 low word", {32'b0, d}, 64'h0000_0000_ABCD_FFFE);
    csr_read(4'd5, 1'b1, d);
    check("R5 high word", {32'b0, d}, 64'h0000_0000_1234_5678);
    @(negedge clk);
    csr_addr = 5'd18;
    @(negedge clk);
    #1 check("R5 hold", {32'b0, csr_rdata}, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_order();
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = {4'd3, 1'b0}; csr_wdata = 32'h5555_0001;
    loc_read = 1'b1; loc_addr = 20'h3_0010;
    #1;
    check("R7 same cycle old addr", out_addr, 64'h0000_0000_0000_0010);
    check("R7 same cycle old flag", {63'b0, out_is64}, 64'd0);
    @(negedge clk);
    csr_wr = 1'b0;
    #1;
    check("R7 next cycle addr", out_addr, 64'h0000_0000_5555_0010);
    check("R7 next cycle flag", {63'b0, out_is64}, 64'd1);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    b_addr = 64'h0000_0001_2345_6789;
    #1;
    check("R10 bypass wide addr", b_out_addr, 64'h0000_0001_2345_6789);
    check("R10 bypass wide flag", {63'b0, b_is64}, 64'd1);
    @(negedge clk);
    b_addr = 64'h0000_0000_FFFF_0000;
    #1;
    check("R10 bypass narrow addr", b_out_addr, 64'h0000_0000_FFFF_0000);
    check("R10 bypass narrow flag", {63'b0, b_is64}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    loc_read = 1'b0; loc_write = 1'b0; loc_addr = '0; out_wait = 1'b0;
    csr_wr = 1'b0; csr_rd = 1'b0; csr_addr = '0; csr_wdata = '0;
    b_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_handshake();
    t_narrow();
    t_wide();
    t_readback();
    t_order();
    t_bypass();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule